// File: doc/BRIEF.md
# Flash Sector Erase Command Sequencer

This block is the command state machine for the sector erase path of a flash-style memory. Commands arrive as a stream of byte writes. Each write carries an address and a command byte on a valid/ready handshake. A five-cycle unlock and setup prefix, followed by a sector-select command, opens a timed acceptance window. While the window is open, further sector-select writes add sectors to a pending set and restart the window timer. A suspend code is tolerated and has no effect. Any other write cancels the whole request.

When the window expires, an automatic two-phase erase runs with no host timing. It first walks the array and programs every word of the marked sectors to zero. It then waits out an erase interval and sets those words to all ones. After that it clears the pending set and drops back to normal read mode. During the window and the erase, reads that fall inside a marked sector return a status word instead of array data. Reads elsewhere return the array contents. The array is a small behavioural register file whose reset contents are a computed seed pattern.

The write stream applies back-pressure only while the erase is running. In that period `wr_ready` is low and no write is taken. Outside the erase, `wr_ready` is high and a write counts in the cycle where `wr_valid` and `wr_ready` are both high at a rising clock edge. Reads have no back-pressure. A read request is answered one cycle later on `rd_data` with `rd_data_valid`.

Top module: `sector_erase_seq`

## Requirements
- R1: After reset `busy` and `window_open` are 0 and `wr_ready` is 1. The word at sector s, offset o (address bits [11:10] = s, bits [2:0] = o) reads as 16'h5A00 | (8*s + o).
- R2: Five accepted writes (AAH at 555H, 55H at 2AAH, 80H at 555H, AAH at 555H, 55H at 2AAH) followed by 30H at any address open the window. The unlock addresses are compared on address bits [10:0]; the command byte is `wr_data`. The final write marks the sector given by address bits [11:10]. `window_open` and `busy` are 1 from the cycle after that last write.
- R3: A write whose address or byte does not match the next expected step of the sequence returns the machine to read mode. The sequence does not continue, and a later 30H opens no window.
- R4: The window stays open for WIN_CYC cycles after the most recent accepted 30H write. Each 30H accepted during the window restarts this count.
- R5: A 30H written during the window adds the sector in address bits [11:10] to the set that will be erased.
- R6: During the window, a write of B0H changes neither the timer nor the set. Any other byte except 30H closes the window, clears the set and drops `busy` with the array left unchanged.
- R7: When the window expires, every word of the marked sectors is programmed to 0000H and then set to FFFFH. Words of unmarked sectors keep their contents.
- R8: From window expiry until the erase finishes, `busy` is 1, `window_open` is 0 and `wr_ready` is 0.
- R9: A read inside a marked sector while `busy` is 1 returns a status word. Bits 7 and 15 are 0. Bits 6 and 14 are equal and invert on every such read, and the first such read after reset returns 1. Bits 3 and 11 are 0 while the window is open and 1 once the erase has started. All other bits are 0. Reads outside marked sectors return array data.
- R10: When the erase finishes, `busy` falls and reads return array data. A new command sequence is accepted again.
- R11: `rd_data_valid` is 1 exactly one cycle after a cycle with `rd_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Command write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_addr | input | 12 | Write address |
| wr_data | input | 8 | Command byte |
| rd_valid | input | 1 | Read request |
| rd_addr | input | 12 | Read address |
| rd_data | output | 16 | Read data or status word, one cycle after the request |
| rd_data_valid | output | 1 | Marks rd_data as the answer to the previous cycle's request |
| busy | output | 1 | Window open or erase running |
| window_open | output | 1 | Sector acceptance window is open |

## Verification
The assertions assume that `wr_valid` and `rd_valid` are never unknown after reset, and that no write is taken while `wr_ready` is low. The stimulus drives every input from a known value at time zero and changes inputs only on falling edges. It issues writes only when it has seen `wr_ready` high. The window-timing checks rely on the bench sending no write other than 30H or B0H while it waits for the window to run out.

// File: rtl/sect_erase_pkg.sv
package sect_erase_pkg;

  localparam int WORD_W = 16;
  localparam int KEY_AW = 11;

  localparam logic [7:0] K_UNLK1 = 8'hAA;
  localparam logic [7:0] K_UNLK2 = 8'h55;
  localparam logic [7:0] K_SETUP = 8'h80;
  localparam logic [7:0] K_SECT  = 8'h30;
  localparam logic [7:0] K_SUSP  = 8'hB0;

  localparam logic [KEY_AW-1:0] KA_HI = 11'h555;
  localparam logic [KEY_AW-1:0] KA_LO = 11'h2AA;

  typedef enum logic [2:0] {
    SQ_READ, SQ_C1, SQ_C2, SQ_C3, SQ_C4, SQ_C5, SQ_WIN, SQ_RUN
  } seq_st_t;

  typedef enum logic [1:0] {EN_IDLE, EN_ZERO, EN_WIPE} eng_st_t;

  function automatic logic [WORD_W-1:0] seed_word(input int idx);
    return 16'h5A00 | WORD_W'(idx);
  endfunction

endpackage

// File: rtl/se_cmd_fsm.sv
module se_cmd_fsm
  import sect_erase_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_SECT = 4,
  parameter int WIN_CYC  = 5000,
  localparam int SB = $clog2(NUM_SECT),
  localparam int CW = $clog2(WIN_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_fire,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_code,
  input  logic                erase_done,
  output logic                window_open,
  output logic                running,
  output logic                start_erase,
  output logic [NUM_SECT-1:0] sect_mask
);

  seq_st_t             st, st_n;
  logic [CW-1:0]       cnt, cnt_n;
  logic [NUM_SECT-1:0] mask_n;
  logic                start_n;
  logic                step_ok;
  logic                at_hi, at_lo;
  logic [NUM_SECT-1:0] sel;

  assign at_hi = (wr_addr[KEY_AW-1:0] == KA_HI);
  assign at_lo = (wr_addr[KEY_AW-1:0] == KA_LO);
  assign sel   = NUM_SECT'(1) << wr_addr[ADDR_W-1 -: SB];

  always_comb begin
    unique case (st)
      SQ_READ: step_ok = at_hi && (wr_code == K_UNLK1);
      SQ_C1:   step_ok = at_lo && (wr_code == K_UNLK2);
      SQ_C2:   step_ok = at_hi && (wr_code == K_SETUP);
      SQ_C3:   step_ok = at_hi && (wr_code == K_UNLK1);
      SQ_C4:   step_ok = at_lo && (wr_code == K_UNLK2);
      default: step_ok = 1'b0;
    endcase
  end

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    mask_n  = sect_mask;
    start_n = 1'b0;
    unique case (st)
      SQ_READ, SQ_C1, SQ_C2, SQ_C3, SQ_C4: begin
        if (wr_fire) st_n = step_ok ? seq_st_t'(st + 3'd1) : SQ_READ;
      end
      SQ_C5: begin
        if (wr_fire) begin
          if (wr_code == K_SECT) begin
            st_n   = SQ_WIN;
            mask_n = sel;
            cnt_n  = '0;
          end else begin
            st_n = SQ_READ;
          end
        end
      end
      SQ_WIN: begin
        if (wr_fire && wr_code == K_SECT) begin
          mask_n = sect_mask | sel;
          cnt_n  = '0;
        end else if (wr_fire && wr_code != K_SUSP) begin
          st_n   = SQ_READ;
          mask_n = '0;
        end else if (cnt == CW'(WIN_CYC - 1)) begin
          st_n    = SQ_RUN;
          start_n = 1'b1;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      SQ_RUN: begin
        if (erase_done) begin
          st_n   = SQ_READ;
          mask_n = '0;
        end
      end
      default: st_n = SQ_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= SQ_READ;
      cnt         <= '0;
      sect_mask   <= '0;
      start_erase <= 1'b0;
    end else begin
      st          <= st_n;
      cnt         <= cnt_n;
      sect_mask   <= mask_n;
      start_erase <= start_n;
    end
  end

  assign window_open = (st == SQ_WIN);
  assign running     = (st == SQ_RUN);

  // R4
  win_cnt_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    window_open |-> (cnt < CW'(WIN_CYC)));

  // R6
  win_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && wr_fire && wr_code != K_SECT && wr_code != K_SUSP)
    |=> (!window_open && sect_mask == '0));

  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && erase_done) |=> (!running && sect_mask == '0));

  // R2
  win_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    window_open |-> (sect_mask != '0));

endmodule

// File: rtl/se_erase_engine.sv
module se_erase_engine
  import sect_erase_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SECT  = 4,
  parameter int OFF_W     = 3,
  parameter int ERASE_CYC = 20000,
  localparam int SB    = $clog2(NUM_SECT),
  localparam int DEPTH = NUM_SECT << OFF_W,
  localparam int IW    = $clog2(DEPTH),
  localparam int EW    = $clog2(ERASE_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [NUM_SECT-1:0] mask,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic                erase_done,
  output logic [WORD_W-1:0]   rd_word
);

  logic [WORD_W-1:0] mem [DEPTH];
  eng_st_t           es;
  logic [IW-1:0]     idx;
  logic [EW-1:0]     ecnt;
  logic [IW-1:0]     rd_idx;
  logic              unused_mid;

  assign rd_idx     = {rd_addr[ADDR_W-1 -: SB], rd_addr[OFF_W-1:0]};
  assign unused_mid = ^rd_addr[ADDR_W-SB-1:OFF_W];
  assign rd_word    = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= seed_word(i);
      es         <= EN_IDLE;
      idx        <= '0;
      ecnt       <= '0;
      erase_done <= 1'b0;
    end else begin
      erase_done <= 1'b0;
      unique case (es)
        EN_IDLE: begin
          if (start) begin
            es  <= EN_ZERO;
            idx <= '0;
          end
        end
        EN_ZERO: begin
          if (mask[idx[IW-1 -: SB]]) mem[idx] <= '0;
          if (idx == IW'(DEPTH - 1)) begin
            es   <= EN_WIPE;
            ecnt <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        EN_WIPE: begin
          if (ecnt == EW'(ERASE_CYC - 1)) begin
            for (int i = 0; i < DEPTH; i++)
              if (mask[SB'(i >> OFF_W)]) mem[i] <= '1;
            es         <= EN_IDLE;
            erase_done <= 1'b1;
          end else begin
            ecnt <= ecnt + 1'b1;
          end
        end
        default: es <= EN_IDLE;
      endcase
    end
  end

  // R7
  phase_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (es != EN_IDLE) |-> (mask != '0));

  // R7
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (es == EN_ZERO && mask[idx[IW-1 -: SB]]) |=> (mem[$past(idx)] == '0));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |=> !erase_done);

endmodule

// File: rtl/se_read_port.sv
module se_read_port
  import sect_erase_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_SECT = 4,
  localparam int SB = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_valid,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [NUM_SECT-1:0] mask,
  input  logic                running,
  input  logic [WORD_W-1:0]   rd_word,
  output logic [WORD_W-1:0]   rd_data,
  output logic                rd_data_valid
);

  logic              hit;
  logic              tgl;
  logic [WORD_W-1:0] stat;

  assign hit = mask[rd_addr[ADDR_W-1 -: SB]];

  always_comb begin
    stat     = '0;
    stat[6]  = ~tgl;
    stat[14] = ~tgl;
    stat[3]  = running;
    stat[11] = running;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgl           <= 1'b0;
      rd_data       <= '0;
      rd_data_valid <= 1'b0;
    end else begin
      rd_data_valid <= rd_valid;
      if (rd_valid) begin
        rd_data <= hit ? stat : rd_word;
        if (hit) tgl <= ~tgl;
      end
    end
  end

  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_data_valid);

  // R9
  stat_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && hit) |=> (!rd_data[7] && !rd_data[15]
                           && rd_data[6] == rd_data[14]
                           && rd_data[3] == rd_data[11]));

endmodule

// File: rtl/sector_erase_seq.sv
module sector_erase_seq
  import sect_erase_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SECT  = 4,
  parameter int OFF_W     = 3,
  parameter int WIN_CYC   = 5000,
  parameter int ERASE_CYC = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_data_valid,
  output logic              busy,
  output logic              window_open
);

  logic                running;
  logic                start_erase;
  logic                erase_done;
  logic [NUM_SECT-1:0] sect_mask;
  logic [WORD_W-1:0]   rd_word;
  logic                wr_fire;

  assign wr_ready = !running;
  assign wr_fire  = wr_valid && wr_ready;
  assign busy     = window_open || running;

  se_cmd_fsm #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .WIN_CYC(WIN_CYC)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_code(wr_data), .erase_done(erase_done), .window_open(window_open),
    .running(running), .start_erase(start_erase), .sect_mask(sect_mask)
  );

  se_erase_engine #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .OFF_W(OFF_W), .ERASE_CYC(ERASE_CYC)
  ) eng_i (
    .clk(clk), .rst_n(rst_n), .start(start_erase), .mask(sect_mask),
    .rd_addr(rd_addr), .erase_done(erase_done), .rd_word(rd_word)
  );

  se_read_port #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT)
  ) rdp_i (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .mask(sect_mask), .running(running), .rd_word(rd_word),
    .rd_data(rd_data), .rd_data_valid(rd_data_valid)
  );

  // R8
  run_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(window_open) && busy) |-> !wr_ready);

endmodule

// File: tb/sector_erase_seq_tb.sv
`timescale 1ns/1ps
module sector_erase_seq_tb_top;

  localparam int WIN = 20;
  localparam int ERS = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [11:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_valid = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_data_valid;
  logic        busy;
  logic        window_open;

  int checks = 0;
  int fails  = 0;
  logic tgl_model = 1'b0;

  always #2.5 clk = ~clk;

  sector_erase_seq #(.WIN_CYC(WIN), .ERASE_CYC(ERS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_data_valid(rd_data_valid),
    .busy(busy), .window_open(window_open)
  );

  // fields: [9:8] first sector, [7:4] extra sectors, [3:1] corrupted step, [0] abort
  localparam logic [9:0] SCN [6] = '{
    {2'd0, 4'b0000, 3'd0, 1'b0},
    {2'd2, 4'b1010, 3'd0, 1'b0},
    {2'd1, 4'b0000, 3'd3, 1'b0},
    {2'd3, 4'b0000, 3'd0, 1'b1},
    {2'd0, 4'b0001, 3'd0, 1'b0},
    {2'd1, 4'b0100, 3'd5, 1'b0}
  };

  function automatic logic [15:0] seed(input int s, input int o);
    return 16'h5A00 | 16'(8 * s + o);
  endfunction

  function automatic logic [11:0] saddr(input int s, input int o);
    return 12'((s << 10) | o);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tgl_model = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    rd_valid = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    d = rd_data;
    chk("R11 read valid", 16'(rd_data_valid), 16'd1);
  endtask

  task automatic seq6(input int s, input int bad);
    logic [11:0] a [6];
    logic [7:0]  d [6];
    a = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA, saddr(s, 3)};
    d = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
    for (int k = 0; k < 6; k++) wr(a[k], (bad == k + 1) ? 8'h00 : d[k]);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
  endtask

  task automatic check_array(input string req, input logic [3:0] erased);
    logic [15:0] v;
    for (int s = 0; s < 4; s++) begin
      rd(saddr(s, 0), v);
      chk(req, v, erased[s] ? 16'hFFFF : seed(s, 0));
      rd(saddr(s, 5), v);
      chk(req, v, erased[s] ? 16'hFFFF : seed(s, 5));
    end
  endtask

  function automatic logic [15:0] stat_exp(input logic t, input logic run);
    logic [15:0] w = '0;
    w[6] = t; w[14] = t; w[3] = run; w[11] = run;
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [3:0]  emask;
    do_reset();

    // R1 reset state
    chk("R1 busy", 16'(busy), 16'd0);
    chk("R1 window", 16'(window_open), 16'd0);
    chk("R1 ready", 16'(wr_ready), 16'd1);
    rd(saddr(2, 1), v);
    chk("R1 seed", v, seed(2, 1));

    // table of scenarios: R2 R3 R5 R6 R7 R9 R10
    for (int n = 0; n < 6; n++) begin
      int first, bad;
      logic [3:0] extra;
      logic ab;
      first = int'(SCN[n][9:8]); extra = SCN[n][7:4];
      bad = int'(SCN[n][3:1]); ab = SCN[n][0];
      do_reset();
      seq6(first, bad);
      for (int s = 0; s < 4; s++) if (extra[s]) wr(saddr(s, 1), 8'h30);
      if (ab) wr(saddr(0, 0), 8'hF0);
      emask = (bad != 0 || ab) ? 4'b0 : (4'(1 << first) | extra);
      chk("R2 R3 R6 window", 16'(window_open), 16'(emask != 0));
      chk("R2 R6 busy", 16'(busy), 16'(emask != 0));
      if (emask != 0) begin
        rd(saddr(first, 2), v);
        tgl_model = ~tgl_model;
        chk("R9 status in window", v, stat_exp(tgl_model, 1'b0));
        wait_idle();
      end
      chk("R10 idle", 16'(busy), 16'd0);
      check_array("R5 R7 contents", emask);
    end

    // R4 window length, R8 back-pressure, R9 status after close
    do_reset();
    seq6(2, 0);
    repeat (WIN - 1) @(negedge clk);
    chk("R4 open at last cycle", 16'(window_open), 16'd1);
    @(negedge clk);
    chk("R4 closed", 16'(window_open), 16'd0);
    chk("R8 busy", 16'(busy), 16'd1);
    chk("R8 ready low", 16'(wr_ready), 16'd0);
    rd(saddr(2, 4), v);
    tgl_model = ~tgl_model;
    chk("R9 status running", v, stat_exp(tgl_model, 1'b1));
    rd(saddr(2, 6), v);
    tgl_model = ~tgl_model;
    chk("R9 toggle", v, stat_exp(tgl_model, 1'b1));
    rd(saddr(0, 2), v);
    chk("R9 unmarked read", v, seed(0, 2));
    wait_idle();
    check_array("R7 single", 4'b0100);

    // R4 retrigger, R6 suspend code ignored
    do_reset();
    seq6(1, 0);
    repeat (WIN - 5) @(negedge clk);
    wr(saddr(3, 0), 8'h30);
    wr(saddr(0, 0), 8'hB0);
    repeat (WIN - 2) @(negedge clk);
    chk("R4 retrigger open", 16'(window_open), 16'd1);
    @(negedge clk);
    chk("R4 R6 closed after retrigger", 16'(window_open), 16'd0);
    wait_idle();
    check_array("R5 R6 suspend ignored", 4'b1010);

    // R10 new sequence accepted after completion
    seq6(0, 0);
    chk("R10 reaccept", 16'(window_open), 16'd1);
    wait_idle();
    rd(saddr(0, 7), v);
    chk("R10 read mode", v, 16'hFFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule